// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, every cycle, whether a five-stage in-order pipeline has to stop fetching, hold its decode register or send an empty slot into the execute stage. It looks at the instruction now in decode (opcode, funct and its two register fields) and at the destination, write-enable and load flags of the entries in the execute, memory and write-back pipeline registers. It drives four control pins, which are all combinational from the current inputs and one small counter. A bubble is an entry whose valid bit is cleared. The block creates bubbles by clearing valid bits, and it ignores entries whose valid bit is low.

Branches and jumps are not predicted. Their outcome and target become known only when the control-flow instruction reaches the memory stage. For this reason, once such an instruction leaves decode, the PC is frozen and the decode register is filled with bubbles for a fixed window of `BR_STALL` cycles (3 by default).

Read-after-write checks use one of two variants, chosen by a parameter. With forwarding (`FORWARD=1`), only a load in execute whose result is needed in decode causes a stall. Without forwarding, any pending writer in execute or memory causes a stall. A writer in write-back also causes a stall unless the register file writes before it reads (`WB_SPLIT=1`). All pins are plain control levels. The block has no data streams and no handshake.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: With FORWARD=1, suppose decode holds a valid instruction and execute holds a valid load (ex_load=1, ex_wr=1) whose nonzero destination equals a field that the instruction reads. In that cycle pc_hold, ifid_hold, idex_bubble and data_hazard are all 1 and ifid_kill is 0.
- R2: With FORWARD=0, a valid writer in execute or memory whose nonzero destination matches a read field stalls decode, whether or not it is a load. A matching writer in write-back stalls decode only when WB_SPLIT=0.
- R3: A comparison never reports a hazard when the destination is register 0, when the entry's write flag is low, or when the entry's valid bit is low.
- R4: Source usage is decided by the opcode (bits 31:26) and the funct field (bits 5:0). Opcode 0x00 reads rs and rt. The exceptions under 0x00 are funct 0x00 and 0x02 (shifts), which read only rt, and funct 0x08 (register jump), which reads only rs. Opcodes 0x08–0x0D and load 0x23 read only rs. Store 0x2B and branches 0x04/0x05 read rs and rt. 0x0F, 0x02 and 0x03 read nothing. Unknown opcodes read nothing.
- R5: A valid branch (opcode 0x04/0x05) or jump (0x02, 0x03, or 0x00 with funct 0x08) in decode with no data stall starts a window. In that cycle and the next BR_STALL-1 cycles, pc_hold=1 and ifid_kill=1, while ifid_hold, idex_bubble and data_hazard are 0. In the following cycle fetch is released.
- R6: A branch or jump that has a data hazard of its own is first held in decode with a data stall. Its window starts in the first cycle in which the hazard is gone.
- R7: While a window is running, read-after-write conditions are ignored (data_hazard stays 0). A further branch, jump or load-use condition in decode does not restart or extend the window.
- R8: When decode is not valid and no window is running, all four control outputs and data_hazard are 0.
- R9: While rst_n is low the window counter is cleared, and once reset is released with idle inputs all outputs are 0.
- R10: With FORWARD=1, a non-load writer in execute and any writer in memory or write-back never cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode register holds a real instruction |
| id_opcode | input | 6 | Opcode field of the decode instruction |
| id_funct | input | 6 | Funct field of the decode instruction |
| id_rs | input | 5 | First register field |
| id_rt | input | 5 | Second register field |
| ex_valid | input | 1 | Execute entry valid |
| ex_wr | input | 1 | Execute entry writes a register |
| ex_load | input | 1 | Execute entry is a load |
| ex_dst | input | 5 | Execute entry destination |
| mem_valid | input | 1 | Memory entry valid |
| mem_wr | input | 1 | Memory entry writes a register |
| mem_dst | input | 5 | Memory entry destination |
| wb_valid | input | 1 | Write-back entry valid |
| wb_wr | input | 1 | Write-back entry writes a register |
| wb_dst | input | 5 | Write-back entry destination |
| pc_hold | output | 1 | Keep the PC this cycle |
| ifid_hold | output | 1 | Keep the decode register contents |
| ifid_kill | output | 1 | Load the decode register with a bubble |
| idex_bubble | output | 1 | Load the execute register with a bubble |
| data_hazard | output | 1 | A read-after-write stall is being taken this cycle |

## Verification
A wrong source-usage decision or a wrong stage comparison shows up at once, in the same cycle the instruction sits in decode, as a stall that is missing or one that should not be there. A window counter that is stuck, restarted or off by one shows up within BR_STALL+1 cycles, because ifid_kill lasts for the wrong number of cycles or data_hazard appears while fetch should still be frozen. The bench runs the forwarding and non-forwarding variants side by side on the same inputs, so faults in either comparison path are exposed.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int REG_W = 5;
  localparam int OP_W  = 6;

  typedef logic [REG_W-1:0] reg_idx_t;
  typedef logic [OP_W-1:0]  op_t;

  localparam op_t OP_SPECIAL = 6'h00;
  localparam op_t OP_JUMP    = 6'h02;
  localparam op_t OP_JLINK   = 6'h03;
  localparam op_t OP_BR_EQ   = 6'h04;
  localparam op_t OP_BR_NE   = 6'h05;
  localparam op_t OP_IMM_LO  = 6'h08;
  localparam op_t OP_IMM_HI  = 6'h0D;
  localparam op_t OP_UPPER   = 6'h0F;
  localparam op_t OP_LOAD    = 6'h23;
  localparam op_t OP_STORE   = 6'h2B;

  localparam op_t FN_SHL     = 6'h00;
  localparam op_t FN_SHR     = 6'h02;
  localparam op_t FN_JREG    = 6'h08;

  localparam int NUM_STAGES  = 3;

  typedef struct packed {
    logic     valid;
    logic     wr;
    logic     load;
    reg_idx_t dst;
  } stage_t;

  typedef struct packed {
    logic rs_used;
    logic rt_used;
    logic is_branch;
    logic is_jump;
  } src_use_t;
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import hazard_pkg::*;
(
  input  op_t      opcode,
  input  op_t      funct,
  output src_use_t use_o
);
  always_comb begin
    use_o = '0;
    if (opcode == OP_SPECIAL) begin
      if (funct == FN_SHL || funct == FN_SHR) begin
        use_o.rt_used = 1'b1;
      end else if (funct == FN_JREG) begin
        use_o.rs_used = 1'b1;
        use_o.is_jump = 1'b1;
      end else begin
        use_o.rs_used = 1'b1;
        use_o.rt_used = 1'b1;
      end
    end else if (opcode == OP_JUMP || opcode == OP_JLINK) begin
      use_o.is_jump = 1'b1;
    end else if (opcode == OP_BR_EQ || opcode == OP_BR_NE) begin
      use_o.rs_used   = 1'b1;
      use_o.rt_used   = 1'b1;
      use_o.is_branch = 1'b1;
    end else if (opcode >= OP_IMM_LO && opcode <= OP_IMM_HI) begin
      use_o.rs_used = 1'b1;
    end else if (opcode == OP_LOAD) begin
      use_o.rs_used = 1'b1;
    end else if (opcode == OP_STORE) begin
      use_o.rs_used = 1'b1;
      use_o.rt_used = 1'b1;
    end
  end

  // R4
  always_comb begin
    if (opcode == OP_UPPER) begin
      upper_reads_none_chk: assert (!use_o.rs_used && !use_o.rt_used);
    end
  end
endmodule

// File: rtl/hz_raw_match.sv
module hz_raw_match
  import hazard_pkg::*;
#(
  parameter int STAGE_KIND = 0,
  parameter bit FORWARD    = 1'b1,
  parameter bit WB_SPLIT   = 1'b1
) (
  input  stage_t   st,
  input  reg_idx_t rs,
  input  reg_idx_t rt,
  input  logic     rs_used,
  input  logic     rt_used,
  output logic     hit
);
  localparam bit LOAD_ONLY = (STAGE_KIND == 0) && FORWARD;
  localparam bit ALWAYS_ON = (STAGE_KIND == 0) ? !FORWARD :
                             (STAGE_KIND == 1) ? !FORWARD :
                             (!FORWARD && !WB_SPLIT);

  logic gate;
  logic writer;
  logic rs_eq;
  logic rt_eq;

  assign gate   = ALWAYS_ON | (LOAD_ONLY & st.load);
  assign writer = st.valid & st.wr & (st.dst != '0);
  assign rs_eq  = rs_used & (rs == st.dst);
  assign rt_eq  = rt_used & (rt == st.dst);
  assign hit    = gate & writer & (rs_eq | rt_eq);

  // R3
  always_comb begin
    if (st.dst == '0 || !st.valid) begin
      zero_or_empty_chk: assert (!hit);
    end
  end
endmodule

// File: rtl/hz_branch_window.sv
module hz_branch_window #(
  parameter int BR_STALL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic active
);
  localparam int CW = (BR_STALL < 2) ? 1 : $clog2(BR_STALL);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BR_STALL - 1);

  logic [CW-1:0] cnt;

  assign busy   = (cnt != '0);
  assign active = start | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (start) begin
      cnt <= LOAD_VAL;
    end
  end

  // R7
  cnt_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == $past(cnt) - 1'b1));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_VAL);
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hazard_pkg::*;
#(
  parameter bit FORWARD  = 1'b1,
  parameter bit WB_SPLIT = 1'b1,
  parameter int BR_STALL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_valid,
  input  logic [5:0] id_opcode,
  input  logic [5:0] id_funct,
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic       ex_valid,
  input  logic       ex_wr,
  input  logic       ex_load,
  input  logic [4:0] ex_dst,
  input  logic       mem_valid,
  input  logic       mem_wr,
  input  logic [4:0] mem_dst,
  input  logic       wb_valid,
  input  logic       wb_wr,
  input  logic [4:0] wb_dst,
  output logic       pc_hold,
  output logic       ifid_hold,
  output logic       ifid_kill,
  output logic       idex_bubble,
  output logic       data_hazard
);
  src_use_t             src_use;
  stage_t               stg [NUM_STAGES];
  logic [NUM_STAGES-1:0] hits;
  logic                 raw_any;
  logic                 win_busy;
  logic                 win_active;
  logic                 data_stall;
  logic                 win_start;

  hz_src_decode u_decode (
    .opcode (id_opcode),
    .funct  (id_funct),
    .use_o  (src_use)
  );

  assign stg[0] = '{valid: ex_valid,  wr: ex_wr,  load: ex_load, dst: ex_dst};
  assign stg[1] = '{valid: mem_valid, wr: mem_wr, load: 1'b0,    dst: mem_dst};
  assign stg[2] = '{valid: wb_valid,  wr: wb_wr,  load: 1'b0,    dst: wb_dst};

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
    hz_raw_match #(
      .STAGE_KIND (g),
      .FORWARD    (FORWARD),
      .WB_SPLIT   (WB_SPLIT)
    ) u_match (
      .st      (stg[g]),
      .rs      (id_rs),
      .rt      (id_rt),
      .rs_used (src_use.rs_used),
      .rt_used (src_use.rt_used),
      .hit     (hits[g])
    );
  end

  assign raw_any    = |hits;
  assign data_stall = id_valid & ~win_busy & raw_any;
  assign win_start  = id_valid & ~win_busy & ~raw_any &
                      (src_use.is_branch | src_use.is_jump);

  hz_branch_window #(.BR_STALL(BR_STALL)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (win_start),
    .busy   (win_busy),
    .active (win_active)
  );

  assign pc_hold     = data_stall | win_active;
  assign ifid_hold   = data_stall;
  assign idex_bubble = data_stall;
  assign ifid_kill   = win_active;
  assign data_hazard = data_stall;

  // R1
  bubble_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (pc_hold && ifid_hold && !ifid_kill));

  // R7
  kill_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_kill |-> (!ifid_hold && !data_hazard && pc_hold));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && !win_busy) |-> (!pc_hold && !ifid_kill && !idex_bubble));

  if (BR_STALL > 1) begin : g_len_chk
    // R5
    kill_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ifid_kill) |=> ifid_kill);
  end
endmodule

// File: tb/hazard_stall_ctrl_bench.sv
module hazard_stall_ctrl_bench;
  localparam int BRS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       id_valid = 0;
  logic [5:0] id_opcode = 0, id_funct = 0;
  logic [4:0] id_rs = 0, id_rt = 0;
  logic       ex_valid = 0, ex_wr = 0, ex_load = 0;
  logic [4:0] ex_dst = 0;
  logic       mem_valid = 0, mem_wr = 0;
  logic [4:0] mem_dst = 0;
  logic       wb_valid = 0, wb_wr = 0;
  logic [4:0] wb_dst = 0;

  logic a_pc, a_hold, a_kill, a_bub, a_dh;
  logic b_pc, b_hold, b_kill, b_bub, b_dh;

  hazard_stall_ctrl u_hazard_stall_ctrl (
    .clk, .rst_n, .id_valid, .id_opcode, .id_funct, .id_rs, .id_rt,
    .ex_valid, .ex_wr, .ex_load, .ex_dst, .mem_valid, .mem_wr, .mem_dst,
    .wb_valid, .wb_wr, .wb_dst,
    .pc_hold(a_pc), .ifid_hold(a_hold), .ifid_kill(a_kill),
    .idex_bubble(a_bub), .data_hazard(a_dh));

  hazard_stall_ctrl #(.FORWARD(1'b0), .WB_SPLIT(1'b0), .BR_STALL(BRS)) u_nofwd (
    .clk, .rst_n, .id_valid, .id_opcode, .id_funct, .id_rs, .id_rt,
    .ex_valid, .ex_wr, .ex_load, .ex_dst, .mem_valid, .mem_wr, .mem_dst,
    .wb_valid, .wb_wr, .wb_dst,
    .pc_hold(b_pc), .ifid_hold(b_hold), .ifid_kill(b_kill),
    .idex_bubble(b_bub), .data_hazard(b_dh));

  int checks = 0;
  int errors = 0;
  int cnt_a = 0;
  int cnt_b = 0;
  bit done = 0;

  function automatic bit uses_rs();
    case (id_opcode)
      6'h00: return !(id_funct == 6'h00 || id_funct == 6'h02);
      6'h04, 6'h05, 6'h23, 6'h2B: return 1;
      6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit uses_rt();
    case (id_opcode)
      6'h00: return id_funct != 6'h08;
      6'h04, 6'h05, 6'h2B: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_ctl();
    return id_opcode == 6'h02 || id_opcode == 6'h03 || id_opcode == 6'h04 ||
           id_opcode == 6'h05 || (id_opcode == 6'h00 && id_funct == 6'h08);
  endfunction

  function automatic bit reads(input logic [4:0] d);
    return d != 0 && ((uses_rs() && id_rs == d) || (uses_rt() && id_rt == d));
  endfunction

  function automatic bit model_raw(input bit fwd, input bit split);
    bit r;
    if (fwd) r = ex_valid && ex_wr && ex_load && reads(ex_dst);
    else begin
      r = (ex_valid && ex_wr && reads(ex_dst)) ||
          (mem_valid && mem_wr && reads(mem_dst)) ||
          (!split && wb_valid && wb_wr && reads(wb_dst));
    end
    return r;
  endfunction

  // {pc_hold, ifid_hold, ifid_kill, idex_bubble, data_hazard}
  function automatic logic [4:0] model_out(input bit fwd, input bit split,
                                           input int cnt, output int nxt);
    bit busy = cnt != 0;
    bit raw  = model_raw(fwd, split);
    bit ds   = id_valid && !busy && raw;
    bit st   = id_valid && !busy && !raw && is_ctl();
    bit win  = st || busy;
    nxt = busy ? cnt - 1 : (st ? BRS - 1 : 0);
    return {ds || win, ds, win, ds, ds};
  endfunction

  task automatic check_now(input string tag);
    logic [4:0] ea, eb, ga, gb;
    int na, nb;
    #1;
    ea = model_out(1'b1, 1'b1, cnt_a, na);
    eb = model_out(1'b0, 1'b0, cnt_b, nb);
    ga = {a_pc, a_hold, a_kill, a_bub, a_dh};
    gb = {b_pc, b_hold, b_kill, b_bub, b_dh};
    checks += 2;
    if (ga !== ea) begin
      errors++;
      $display("FAIL %s fwd: got %b expected %b", tag, ga, ea);
    end
    if (gb !== eb) begin
      errors++;
      $display("FAIL %s nofwd: got %b expected %b", tag, gb, eb);
    end
    cnt_a = na;
    cnt_b = nb;
  endtask

  task automatic set_id(input bit v, input logic [5:0] op, input logic [5:0] fn,
                        input logic [4:0] rs, input logic [4:0] rt);
    id_valid = v; id_opcode = op; id_funct = fn; id_rs = rs; id_rt = rt;
  endtask

  task automatic set_stg(input bit ev, input bit ew, input bit el, input logic [4:0] ed,
                         input bit mv, input bit mw, input logic [4:0] md,
                         input bit wv, input bit ww, input logic [4:0] wd);
    ex_valid = ev; ex_wr = ew; ex_load = el; ex_dst = ed;
    mem_valid = mv; mem_wr = mw; mem_dst = md;
    wb_valid = wv; wb_wr = ww; wb_dst = wd;
  endtask

  task automatic idle();
    set_id(0, 0, 0, 0, 0);
    set_stg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_now("R9 reset idle");

    // R1 load-use on rs
    @(negedge clk); set_id(1, 6'h00, 6'h20, 5'd2, 5'd1);
    set_stg(1, 1, 1, 5'd2, 0, 0, 0, 0, 0, 0); check_now("R1 load-use");
    // R10 non-load writer in EX with forwarding
    @(negedge clk); set_stg(1, 1, 0, 5'd2, 1, 1, 5'd1, 1, 1, 5'd1); check_now("R10 R2 non-load");
    // R2 WB-only match
    @(negedge clk); set_stg(0, 0, 0, 0, 0, 0, 0, 1, 1, 5'd1); check_now("R2 wb match");
    // R3 destination zero, write low, invalid
    @(negedge clk); set_id(1, 6'h00, 6'h20, 5'd0, 5'd0);
    set_stg(1, 1, 1, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0); check_now("R3 dst zero");
    @(negedge clk); set_id(1, 6'h00, 6'h20, 5'd3, 5'd3);
    set_stg(1, 0, 1, 5'd3, 1, 0, 5'd3, 0, 1, 5'd3); check_now("R3 wr low/invalid");
    // R4 upper-immediate reads nothing; shift ignores rs; imm ignores rt
    @(negedge clk); set_id(1, 6'h0F, 6'h00, 5'd4, 5'd4);
    set_stg(1, 1, 1, 5'd4, 1, 1, 5'd4, 1, 1, 5'd4); check_now("R4 upper");
    @(negedge clk); set_id(1, 6'h00, 6'h00, 5'd4, 5'd5); check_now("R4 shift rs");
    @(negedge clk); set_id(1, 6'h09, 6'h00, 5'd6, 5'd4); check_now("R4 imm rt");
    @(negedge clk); set_id(1, 6'h2B, 6'h00, 5'd6, 5'd4); check_now("R4 store rt");
    // R8 invalid decode
    @(negedge clk); set_id(0, 6'h2B, 6'h00, 5'd4, 5'd4); check_now("R8 invalid id");

    // R5 branch window then release
    @(negedge clk); set_stg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    set_id(1, 6'h04, 6'h00, 5'd1, 5'd2); check_now("R5 branch start");
    @(negedge clk); set_id(0, 0, 0, 0, 0); check_now("R5 window 2");
    @(negedge clk); check_now("R5 window 3");
    @(negedge clk); check_now("R5 release");

    // R6 jump-register with load-use, then window
    @(negedge clk); set_id(1, 6'h00, 6'h08, 5'd7, 5'd0);
    set_stg(1, 1, 1, 5'd7, 0, 0, 0, 0, 0, 0); check_now("R6 jr held");
    @(negedge clk); set_stg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); check_now("R6 jr start");
    // R7 load-use and another jump during window ignored
    @(negedge clk); set_id(1, 6'h00, 6'h20, 5'd7, 5'd7);
    set_stg(1, 1, 1, 5'd7, 1, 1, 5'd7, 0, 0, 0); check_now("R7 ignore raw");
    @(negedge clk); set_id(1, 6'h02, 6'h00, 0, 0);
    set_stg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); check_now("R7 no restart");
    @(negedge clk); check_now("R7 new jump after window");
    @(negedge clk); idle(); check_now("R7 window");
    @(negedge clk); check_now("R7 window end");
    @(negedge clk); check_now("R8 quiet");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      @(negedge clk);
      k = $urandom_range(0, 11);
      case (k)
        0: set_id(1, 6'h00, 6'h20, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        1: set_id(1, 6'h00, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        2: set_id(1, 6'h00, 6'h08, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        3: set_id(1, 6'h02, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        4: set_id(1, 6'h05, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        5: set_id(1, 6'h0C, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        6: set_id(1, 6'h0F, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        7: set_id(1, 6'h23, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        8: set_id(1, 6'h2B, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        9: set_id(1, 6'h3F, 6'h00, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        10: set_id(1, 6'h00, 6'h02, 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
        default: set_id(0, 6'h00, 6'h20, 5'd1, 5'd1);
      endcase
      if (k < 11 && $urandom_range(0, 2) == 0) id_valid = 0;
      set_stg($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, 5'($urandom_range(0, 3)),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              5'($urandom_range(0, 3)),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              5'($urandom_range(0, 3)));
      check_now("R1/R2/R3/R4/R5/R6/R7/R10 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule